// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Self-Refresh Sequencing

This block owns the refresh duty of a DDR SDRAM controller. An interval timer, sized from the clock period and the required average refresh spacing, produces one tick per refresh period. Each tick adds one unit of refresh debt. While debt is outstanding the block asks the command arbiter for a slot. The arbiter may postpone these requests to serve traffic, up to a ceiling of eight owed refreshes. At that ceiling the block raises an urgent flag, and the arbiter must grant on its next free slot. Every grant produces exactly one refresh command, with the address bus held at zero.

The block also runs the low-power sequence. A sleep request is taken only when no refresh is owed and the arbiter reports itself idle. The block then emits the self-refresh command with CKE low in that same cycle and keeps CKE low until woken. After a wake request it lets the clock settle for a set number of cycles before raising CKE. It then holds the arbiter to NOPs for a fixed lockout window. When the lockout ends, normal operation resumes with the interval timer starting again from zero.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is held (active-low, synchronous), cmd_o is NOP (code 0), cke_o is 1, and ref_req_o, ref_urgent_o, debt_err_o and hold_nop_o are 0. addr_o is all zeros.
- R2: In normal operation one interval tick occurs every TREFI clock cycles, counted from reset release or from return to normal operation, and each tick adds one owed refresh. ref_req_o is high exactly while at least one refresh is owed and the block is in normal operation. TREFI is REFI_NS*1000/CLK_PERIOD_PS.
- R3: A cycle with ref_req_o and ref_gnt both high retires one owed refresh. In the next cycle cmd_o shows AUTO REFRESH (code 1) for one cycle, with addr_o zero. No refresh command appears without a grant.
- R4: ref_urgent_o is high exactly while MAX_DEBT (8) refreshes are owed.
- R5: When a tick and a granted refresh fall in the same cycle, the owed count is unchanged.
- R6: A tick while MAX_DEBT refreshes are owed and none is granted leaves the count at MAX_DEBT and sets debt_err_o. debt_err_o then stays set until reset.
- R7: If the arbiter grants only when ref_urgent_o is high, the gap between two consecutive refresh commands never exceeds nine intervals.
- R8: sleep_req is accepted only in normal operation with no refresh owed, arb_idle high and no tick in that cycle. On acceptance, the next cycle shows cmd_o = SELF REFRESH (code 2) with cke_o low. cke_o then stays low until the wake sequence raises it.
- R9: cke_o rises exactly SETTLE_CYC cycles after the clock edge that samples wake_req in self-refresh.
- R10: After cke_o rises, hold_nop_o stays high with cke_o high for exactly LOCK_CYC cycles. During that window cmd_o is NOP and ref_req_o is low, even with ref_gnt held high.
- R11: After the lockout ends, the first tick comes exactly TREFI cycles later.
- R12: sleep_req has no effect while a refresh is owed, while arb_idle is low, or outside normal operation. wake_req has no effect outside self-refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arb_idle | input | 1 | Arbiter has no traffic in flight |
| ref_gnt | input | 1 | Arbiter grants the refresh slot this cycle |
| sleep_req | input | 1 | Request to enter self-refresh |
| wake_req | input | 1 | Request to leave self-refresh |
| ref_req_o | output | 1 | At least one refresh is owed |
| ref_urgent_o | output | 1 | Postponement ceiling reached; grant on next idle slot |
| cmd_o | output | 2 | 0 NOP, 1 AUTO REFRESH, 2 SELF REFRESH entry |
| cke_o | output | 1 | Clock enable to the DRAM |
| addr_o | output | ADDR_W | Address bus, zero during refresh commands |
| hold_nop_o | output | 1 | Arbiter must issue only NOPs (self-refresh, settle, lockout) |
| debt_err_o | output | 1 | Sticky: a tick arrived with the debt already full |

## Verification
The bench lets debt pile up to the ceiling and past it. A counter that wrapped or failed to saturate would show a spurious drop of the urgent flag or a missing error flag. Grants are landed on the exact cycle of a tick, where a design that let one update win would show one owed refresh too many or too few. The wake path is timed edge by edge: a CKE rise that came early, or a lockout one cycle short or long, shows up as a count mismatch. A refresh request leaking into the window, or a timer that resumed mid-count instead of from zero, puts the first request after lockout at the wrong cycle.

// File: rtl/refsch_pkg.sv
// Shared encodings for the refresh scheduler.
// Assumes a two-bit command field decoded by the DRAM command encoder.
package refsch_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_AREF = 2'd1,
        CMD_SREF = 2'd2
    } dram_cmd_e;

    typedef enum logic [1:0] {
        PWR_RUN    = 2'd0,
        PWR_SLEEP  = 2'd1,
        PWR_SETTLE = 2'd2,
        PWR_LOCK   = 2'd3
    } pwr_state_e;

endpackage

// File: rtl/refsch_interval.sv
// Interval timer: pulses tick_o once every TREFI_CYC cycles while run is high.
// Assumes TREFI_CYC >= 2. While run is low the count is held at zero, so
// counting restarts from zero when run returns.
module refsch_interval #(
    parameter int TREFI_CYC = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick_o
);
    localparam int CW = $clog2(TREFI_CYC);
    localparam logic [CW-1:0] LAST = CW'(TREFI_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Advance the interval count; wrap at the end of each period.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run)         cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = run && (cnt_q == LAST);

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/refsch_debt.sv
// Debt counter: counts owed refreshes, saturates at MAX_DEBT, flags overflow.
// Assumes issue is only raised while the count is nonzero.
module refsch_debt #(
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic issue,
    output logic empty_o,
    output logic full_o,
    output logic err_o
);
    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam logic [DW-1:0] FULL = DW'(MAX_DEBT);

    logic [DW-1:0] debt_q;
    logic          err_q;

    // Add a unit per tick, retire one per issue; simultaneous events cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            debt_q <= '0;
        end else begin
            unique case ({tick, issue})
                2'b10:   if (debt_q != FULL) debt_q <= debt_q + 1'b1;
                2'b01:   debt_q <= debt_q - 1'b1;
                default: debt_q <= debt_q;
            endcase
        end
    end

    // Latch the overflow condition until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 err_q <= 1'b0;
        else if (tick && !issue && debt_q == FULL)  err_q <= 1'b1;
    end

    assign empty_o = (debt_q == '0);
    assign full_o  = (debt_q == FULL);
    assign err_o   = err_q;

    // R6
    debt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        debt_q <= FULL);
    // R5
    tick_issue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && issue) |=> $stable(debt_q));
    // R3
    issue_needs_debt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> debt_q != '0);
    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: rtl/refsch_power.sv
// Power sequencer: self-refresh entry, clock settle wait, then NOP lockout.
// Assumes enter is only raised in PWR_RUN. CKE is low from entry until
// SETTLE_CYC cycles after the wake request; then LOCK_CYC lockout cycles follow.
module refsch_power
    import refsch_pkg::*;
#(
    parameter int SETTLE_CYC = 16,
    parameter int LOCK_CYC   = 200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enter,
    input  logic       wake_req,
    output pwr_state_e state_o,
    output logic       cke_o
);
    localparam int TMAX = (SETTLE_CYC > LOCK_CYC) ? SETTLE_CYC : LOCK_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYC - 1);
    localparam logic [TW-1:0] LOCK_LAST   = TW'(LOCK_CYC - 1);

    pwr_state_e    state_q;
    logic [TW-1:0] tmr_q;
    logic          cke_q;

    // Step through run, sleep, settle and lockout phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PWR_RUN;
            tmr_q   <= '0;
            cke_q   <= 1'b1;
        end else begin
            unique case (state_q)
                PWR_RUN: begin
                    if (enter) begin
                        state_q <= PWR_SLEEP;
                        cke_q   <= 1'b0;
                    end
                end
                PWR_SLEEP: begin
                    if (wake_req) begin
                        state_q <= PWR_SETTLE;
                        tmr_q   <= '0;
                    end
                end
                PWR_SETTLE: begin
                    if (tmr_q == SETTLE_LAST) begin
                        state_q <= PWR_LOCK;
                        cke_q   <= 1'b1;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                PWR_LOCK: begin
                    if (tmr_q == LOCK_LAST) state_q <= PWR_RUN;
                    else                    tmr_q   <= tmr_q + 1'b1;
                end
                default: state_q <= PWR_RUN;
            endcase
        end
    end

    assign state_o = state_q;
    assign cke_o   = cke_q;

    // R8
    cke_low_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_SLEEP || state_q == PWR_SETTLE) |-> !cke_q);
    // R9
    cke_rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke_q) |-> $past(state_q) == PWR_SETTLE);
    // R10
    lock_cke_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == PWR_LOCK |-> cke_q);
    // R8
    entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_RUN && enter) |=> (state_q == PWR_SLEEP && !cke_q));

endmodule

// File: rtl/dram_refresh_sched.sv
// Refresh scheduler top: joins the interval timer, debt counter and power
// sequencer, and registers the command seen by the DRAM command encoder.
// Assumes the arbiter raises ref_gnt only for a slot it has reserved.
module dram_refresh_sched
    import refsch_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int REFI_NS       = 7800,
    parameter int MAX_DEBT      = 8,
    parameter int SETTLE_CYC    = 16,
    parameter int LOCK_CYC      = 200,
    parameter int ADDR_W        = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arb_idle,
    input  logic              ref_gnt,
    input  logic              sleep_req,
    input  logic              wake_req,
    output logic              ref_req_o,
    output logic              ref_urgent_o,
    output logic [1:0]        cmd_o,
    output logic              cke_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              hold_nop_o,
    output logic              debt_err_o
);
    localparam int TREFI_CYC = (REFI_NS * 1000) / CLK_PERIOD_PS;

    pwr_state_e pwr_state;
    logic       run, tick, issue, enter;
    logic       debt_empty, debt_full;
    dram_cmd_e  cmd_q;

    assign run   = (pwr_state == PWR_RUN);
    assign issue = ref_req_o && ref_gnt;
    assign enter = run && sleep_req && arb_idle && debt_empty && !tick;

    refsch_interval #(.TREFI_CYC(TREFI_CYC)) u_interval (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick_o (tick)
    );

    refsch_debt #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .issue   (issue),
        .empty_o (debt_empty),
        .full_o  (debt_full),
        .err_o   (debt_err_o)
    );

    refsch_power #(.SETTLE_CYC(SETTLE_CYC), .LOCK_CYC(LOCK_CYC)) u_power (
        .clk      (clk),
        .rst_n    (rst_n),
        .enter    (enter),
        .wake_req (wake_req),
        .state_o  (pwr_state),
        .cke_o    (cke_o)
    );

    // Register the command: refresh on a grant, self-refresh on entry.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmd_q <= CMD_NOP;
        else if (issue) cmd_q <= CMD_AREF;
        else if (enter) cmd_q <= CMD_SREF;
        else            cmd_q <= CMD_NOP;
    end

    assign ref_req_o    = run && !debt_empty;
    assign ref_urgent_o = run && debt_full;
    assign hold_nop_o   = !run;
    assign cmd_o        = cmd_q;
    assign addr_o       = '0;

    // R3
    aref_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q == CMD_AREF |-> $past(ref_req_o && ref_gnt));
    // R8
    sref_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_q == CMD_SREF |-> !cke_o);
    // R10
    lock_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_nop_o && cke_o) |-> (cmd_q == CMD_NOP && !ref_req_o));
    // R4
    urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_urgent_o |-> ref_req_o);

endmodule

// File: tb/dram_refresh_sched_bench.sv
// Scoreboard bench: drivers queue expected commands, a monitor compares them.
module dram_refresh_sched_bench;
    localparam int T   = 20;   // interval cycles: 200 ns at 10 ns clock
    localparam int MAX = 8;
    localparam int W   = 5;
    localparam int L   = 200;

    logic clk = 1'b0;
    logic rst_n, arb_idle, ref_gnt, sleep_req, wake_req;
    logic ref_req_o, ref_urgent_o, cke_o, hold_nop_o, debt_err_o;
    logic [1:0]  cmd_o;
    logic [12:0] addr_o;

    always #5 clk = ~clk;

    dram_refresh_sched #(
        .CLK_PERIOD_PS(10000), .REFI_NS(200), .MAX_DEBT(MAX),
        .SETTLE_CYC(W), .LOCK_CYC(L), .ADDR_W(13)
    ) u_dram_refresh_sched (
        .clk(clk), .rst_n(rst_n), .arb_idle(arb_idle), .ref_gnt(ref_gnt),
        .sleep_req(sleep_req), .wake_req(wake_req), .ref_req_o(ref_req_o),
        .ref_urgent_o(ref_urgent_o), .cmd_o(cmd_o), .cke_o(cke_o),
        .addr_o(addr_o), .hold_nop_o(hold_nop_o), .debt_err_o(debt_err_o)
    );

    int tests = 0, fails = 0;
    int n = 0;                 // edges since reset release
    int ph = 0, debt_m = 0;    // model of interval phase and owed count
    bit err_m = 0, req_s = 0, hold_s = 0;
    int exp_edge[$], exp_code[$];
    int aref_seen = 0, grants = 0, last_aref = -1, max_gap = 0;
    bit track_gap = 0;

    task automatic chk(string tag, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Model update at each edge from values stable since the last negedge.
    always @(posedge clk) begin
        if (!rst_n) begin
            n = 0; ph = 0; debt_m = 0; err_m = 0;
        end else begin
            bit tk, iss;
            n++;
            tk = 0;
            if (hold_s) ph = 0;
            else if (ph == T - 1) begin tk = 1; ph = 0; end
            else ph++;
            iss = req_s && ref_gnt;
            if (tk && !iss) begin
                if (debt_m == MAX) err_m = 1; else debt_m++;
            end else if (!tk && iss) debt_m--;
        end
    end

    // Monitor: continuous model comparison and scoreboard pops.
    always @(negedge clk) begin
        req_s  = ref_req_o;
        hold_s = hold_nop_o;
        if (rst_n && n > 0) begin
            if (hold_nop_o) begin
                chk("R10 req in lockout", ref_req_o, 0);
                if (cke_o) chk("R10 cmd in lockout", cmd_o, 0);
            end else begin
                chk("R2 ref_req vs owed", ref_req_o, debt_m != 0);
                chk("R4 urgent vs owed", ref_urgent_o, debt_m == MAX);
            end
            chk("R6 err flag", debt_err_o, err_m);
            if (cmd_o != 2'd0) begin
                if (exp_edge.size() == 0) begin
                    chk("R3 unexpected command", cmd_o, 0);
                end else begin
                    int e, c;
                    e = exp_edge.pop_front();
                    c = exp_code.pop_front();
                    chk("R3 command edge", n, e);
                    chk("R3 command code", cmd_o, c);
                    if (cmd_o == 2'd1) begin
                        chk("R3 addr zero", addr_o, 0);
                        aref_seen++;
                        if (track_gap && last_aref >= 0 && n - last_aref > max_gap)
                            max_gap = n - last_aref;
                        last_aref = n;
                    end
                end
            end
        end
    end

    // Driver: grant one slot at this negedge, queue the expected refresh.
    task automatic grant_one();
        ref_gnt = 1'b1;
        if (ref_req_o) begin
            exp_edge.push_back(n + 1);
            exp_code.push_back(1);
            grants++;
        end
        @(negedge clk);
        ref_gnt = 1'b0;
    endtask

    task automatic drain();
        while (ref_req_o) grant_one();
    endtask

    task automatic avoid_tick();
        while (ph == T - 1) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++; tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int m, cnt, we, e0;
        rst_n = 0; arb_idle = 1; ref_gnt = 0; sleep_req = 0; wake_req = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cmd", cmd_o, 0);
        chk("R1 cke", cke_o, 1);
        chk("R1 req", ref_req_o, 0);
        chk("R1 urgent", ref_urgent_o, 0);
        chk("R1 err", debt_err_o, 0);
        chk("R1 hold", hold_nop_o, 0);
        chk("R1 addr", addr_o, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 first tick after T edges; R4 urgent after eight
        while (!ref_req_o) @(negedge clk);
        chk("R2 first tick edge", n, T);
        while (!ref_urgent_o) @(negedge clk);
        chk("R4 urgent edge", n, MAX * T);

        // R3 drain: one command per owed refresh
        drain();
        @(negedge clk);
        chk("R3 commands equal grants", aref_seen, grants);

        // R7 grant only on urgent, gap at most nine intervals
        track_gap = 1; max_gap = 0;
        for (int i = 0; i < 3; i++) begin
            while (!ref_urgent_o) @(negedge clk);
            grant_one();
        end
        @(negedge clk);
        track_gap = 0;
        chk("R7 max gap within 9 intervals", max_gap <= 9 * T, 1);
        drain();

        // R6 saturation and sticky error
        while (!ref_urgent_o) @(negedge clk);
        m = n;
        while (!debt_err_o) @(negedge clk);
        chk("R6 err one interval after full", n - m, T);
        chk("R6 urgent stays", ref_urgent_o, 1);
        drain();
        repeat (2) @(negedge clk);
        chk("R6 err sticky after drain", debt_err_o, 1);

        // R5 grant coincides with a tick
        drain();
        while (!ref_req_o) @(negedge clk);
        if (ref_req_o) drain();
        while (!ref_req_o) @(negedge clk);
        while (ph != T - 1) @(negedge clk);
        grant_one();
        chk("R5 owed unchanged after collision", ref_req_o, 1);
        grant_one();
        chk("R5 cleared by next grant", ref_req_o, 0);

        // R12 wake outside self-refresh ignored
        wake_req = 1; @(negedge clk); wake_req = 0; @(negedge clk);
        chk("R12 wake ignored cke", cke_o, 1);
        chk("R12 wake ignored hold", hold_nop_o, 0);

        // R12 sleep refused with debt owed
        while (!ref_req_o) @(negedge clk);
        sleep_req = 1; @(negedge clk); sleep_req = 0; @(negedge clk);
        chk("R12 sleep with debt cke", cke_o, 1);
        chk("R12 sleep with debt hold", hold_nop_o, 0);
        drain();

        // R12 sleep refused while arbiter busy
        avoid_tick();
        arb_idle = 0; sleep_req = 1; @(negedge clk); sleep_req = 0; arb_idle = 1;
        @(negedge clk);
        chk("R12 sleep while busy cke", cke_o, 1);
        drain();

        // R8 entry
        avoid_tick();
        if (ref_req_o) drain();
        avoid_tick();
        exp_edge.push_back(n + 1); exp_code.push_back(2);
        sleep_req = 1; @(negedge clk); sleep_req = 0;
        chk("R8 cmd self refresh", cmd_o, 2);
        chk("R8 cke low with entry", cke_o, 0);
        chk("R8 hold", hold_nop_o, 1);
        cnt = 0;
        for (int i = 0; i < 30; i++) begin
            if (i == 10) sleep_req = 1;  // R12 repeat sleep ignored
            @(negedge clk);
            sleep_req = 0;
            if (!cke_o) cnt++;
        end
        chk("R8 cke stays low", cnt, 30);

        // R9 wake timing
        we = n + 1;
        wake_req = 1; @(negedge clk); wake_req = 0;
        while (!cke_o) @(negedge clk);
        chk("R9 cke rise edge", n, we + W);

        // R10 lockout length with grant held high
        ref_gnt = 1; cnt = 0;
        while (hold_nop_o) begin
            if (cke_o) cnt++;
            @(negedge clk);
        end
        ref_gnt = 0;
        chk("R10 lockout cycles", cnt, L);

        // R11 interval restarts from zero
        e0 = n;
        while (!ref_req_o) @(negedge clk);
        chk("R11 first tick after lockout", n - e0, T);
        drain();
        repeat (3) @(negedge clk);
        chk("R3 scoreboard empty", exp_edge.size(), 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule